// File: doc/BRIEF.md
# UART RTS/CTS Flow-Control Unit

This block is the handshake logic for one serial channel. It sits between the transmit serializer, the receive FIFO and the two handshake pins. On the transmit side it takes an active-low clear-to-send pin and passes it through a synchronizer. It then turns that pin into a transmit-permit signal. The permit can change only when the serializer reports that it is between characters, so a character that has already started always goes out in full. On the receive side it drives an active-low ready-to-send pin from the FIFO state.

RTS is raised (not ready) only when two things happen together: the FIFO is already full, and the deserializer detects the start bit of one more character. That character can still be completed in the receive shift register. A far-end transmitter that obeys the handshake therefore stops with one character more than the FIFO depth held on the receive side: 9 for an 8-entry FIFO, 17 for a 16-entry one. A read that frees a FIFO entry lowers RTS again.

Each function has its own enable. With CTS gating off, the pin has no influence on the transmitter. With RTS control off, the pin carries the general-purpose output level instead. In a normal link, one side's RTS is wired to the partner's CTS.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With CTS gating enabled, in a cycle where `tx_at_boundary` is 1, `tx_permit` is 1 when the `cts_n_pin` level sampled two rising edges earlier was 0. The pin passes through a two-stage synchronizer.
- R2: With CTS gating enabled, in a cycle where `tx_at_boundary` is 1, `tx_permit` is 0 when the `cts_n_pin` level sampled two rising edges earlier was 1.
- R3: In a cycle where `tx_at_boundary` is 0, `tx_permit` keeps the value it had in the most recent boundary cycle. A CTS change during a character therefore takes effect only at the next boundary.
- R4: With CTS gating disabled, `tx_permit` is 1 in every boundary cycle, whatever the level of `cts_n_pin`.
- R5: With RTS control enabled, a cycle that has all of the following drives `rts_n_pin` to 1 from the next cycle on:
  - `rx_fifo_full` = 1
  - `rx_start_det` = 1
  - `rx_fifo_rd` = 0
- R6: Once raised, `rts_n_pin` stays 1 until a cycle with `rx_fifo_rd` = 1, and is 0 from the cycle after that read. A read in the same cycle as full plus start prevents RTS from rising.
- R7: A start bit detected while `rx_fifo_full` = 0 leaves `rts_n_pin` unchanged.
- R8: With RTS control disabled, `rts_n_pin` equals `gpo_level` in the same cycle, and the internal hold state is cleared. Re-enabling RTS control therefore shows 0 until a new full-plus-start event.
- R9: While `rst_n` = 0 the RTS hold state is clear, so with RTS control enabled `rts_n_pin` is 0. The synchronizer holds "not clear", so with gating enabled a boundary cycle gives `tx_permit` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_gate_en | input | 1 | 1: CTS pin gates the transmitter |
| cts_n_pin | input | 1 | Active-low clear-to-send pin, asynchronous |
| tx_at_boundary | input | 1 | 1: serializer is between characters and may start one |
| tx_permit | output | 1 | 1: serializer may start a character |
| rts_ctl_en | input | 1 | 1: receiver state drives the RTS pin |
| rx_fifo_full | input | 1 | Receive FIFO full flag |
| rx_start_det | input | 1 | One-cycle pulse: start bit of a new character detected |
| rx_fifo_rd | input | 1 | One-cycle pulse: one FIFO entry read and freed |
| gpo_level | input | 1 | General-purpose output level used when RTS control is off |
| rts_n_pin | output | 1 | Active-low ready-to-send pin |

## Verification
The bench targets a CTS deassertion that lands in the middle of a character. A design that gated at once would drop `tx_permit` before the boundary. It also times CTS changes against the two-stage synchronizer, which catches a design with too few or too many stages: that design would move the permit one cycle early or late.

On the receive side, the bench fills the FIFO in the "ninth character" sequence and checks that a start bit on a non-full FIFO does nothing. It also checks that RTS does not rise when a read coincides with full plus start, and that a read lowers RTS in the very next cycle. A design with the wrong read/set priority, or one that raised RTS on a full FIFO alone, fails these checks. Finally, the bench toggles the enables mid-stream. This shows whether the released path follows the general output level and whether a stale hold state returns when RTS control is re-enabled.

// File: rtl/uart_fc_pkg.sv
// Package: shared types and decision helpers for the UART flow-control unit.
// Assumes: all handshake pins are active low.
package uart_fc_pkg;

    // Receive-side hold state; the value is the level driven onto the RTS pin.
    typedef enum logic {
        RTS_READY = 1'b0,
        RTS_HOLD  = 1'b1
    } rts_state_e;

    // Decides whether a new character may start, given gating and a synced CTS level.
    function automatic logic fc_send_allowed(input logic gate_en, input logic cts_n_synced);
        return (~gate_en) | (~cts_n_synced);
    endfunction

    // Next hold state from one cycle of receive-side events.
    function automatic rts_state_e fc_rts_next(
        input rts_state_e cur,
        input logic       ctl_en,
        input logic       full,
        input logic       start,
        input logic       rd
    );
        rts_state_e nxt;
        nxt = cur;
        if (!ctl_en || rd) begin
            nxt = RTS_READY;
        end else if (full && start) begin
            nxt = RTS_HOLD;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/uart_fc_sync.sv
// Module: multi-stage synchronizer for a single asynchronous level.
// Assumes: STAGES >= 1; each stage resets to RESET_VAL under synchronous reset.
module uart_fc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage captures the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages shift the sampled level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= RESET_VAL;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/uart_fc_tx_gate.sv
// Module: transmit gate. Converts the synced CTS level into a permit that can
// change only at a character boundary.
// Assumes: tx_at_boundary is 1 in every cycle in which the serializer may
// launch a character, and 0 while a character is being shifted out.
module uart_fc_tx_gate
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic cts_n_synced,
    input  logic at_boundary,
    output logic permit
);
    logic allow_now;
    logic permit_q;

    // Decision for the current cycle from gating and the synced pin.
    always_comb begin
        allow_now = fc_send_allowed(gate_en, cts_n_synced);
    end

    // Hold the decision made at the most recent boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)           permit_q <= 1'b0;
        else if (at_boundary) permit_q <= allow_now;
    end

    // Live decision at a boundary, frozen decision inside a character.
    always_comb begin
        permit = at_boundary ? allow_now : permit_q;
    end
endmodule

// File: rtl/uart_fc_rts.sv
// Module: receive-side RTS control. Raises RTS when a start bit arrives on a
// full FIFO, lowers it on a read, and hands the pin to the GPO path when off.
// Assumes: start and read indications are single-cycle pulses.
module uart_fc_rts
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_en,
    input  logic fifo_full,
    input  logic start_det,
    input  logic fifo_rd,
    input  logic gpo_level,
    output logic rts_n
);
    rts_state_e state_q;
    rts_state_e state_d;

    // Next-state evaluation: a read or a disable wins over a new hold request.
    always_comb begin
        state_d = fc_rts_next(state_q, ctl_en, fifo_full, start_det, fifo_rd);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RTS_READY;
        else        state_q <= state_d;
    end

    // Pin selection between flow control and the general output path.
    always_comb begin
        rts_n = ctl_en ? logic'(state_q) : gpo_level;
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
// Module: per-channel RTS/CTS flow control (top).
// Assumes: cts_n_pin is asynchronous; all other inputs are synchronous to clk.
module uart_flow_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_gate_en,
    input  logic cts_n_pin,
    input  logic tx_at_boundary,
    output logic tx_permit,
    input  logic rts_ctl_en,
    input  logic rx_fifo_full,
    input  logic rx_start_det,
    input  logic rx_fifo_rd,
    input  logic gpo_level,
    output logic rts_n_pin
);
    logic cts_n_synced;

    uart_fc_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_cts_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(cts_n_pin),
        .q_sync (cts_n_synced)
    );

    uart_fc_tx_gate u_tx_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_en     (cts_gate_en),
        .cts_n_synced(cts_n_synced),
        .at_boundary (tx_at_boundary),
        .permit      (tx_permit)
    );

    uart_fc_rts u_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_en   (rts_ctl_en),
        .fifo_full(rx_fifo_full),
        .start_det(rx_start_det),
        .fifo_rd  (rx_fifo_rd),
        .gpo_level(gpo_level),
        .rts_n    (rts_n_pin)
    );
endmodule

// File: rtl/uart_fc_checker.sv
// Module: temporal checks on the flow-control top, bound to every instance.
// Assumes: the synchronizer-latency checks apply only to the two-stage build.
module uart_fc_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cts_gate_en,
    input logic cts_n_pin,
    input logic tx_at_boundary,
    input logic tx_permit,
    input logic rts_ctl_en,
    input logic rx_fifo_full,
    input logic rx_start_det,
    input logic rx_fifo_rd,
    input logic gpo_level,
    input logic rts_n_pin
);
    generate
        if (SYNC_STAGES == 2) begin : g_lat2
            // R1: a low pin two edges back opens the gate at a boundary.
            p_cts_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_at_boundary && cts_gate_en && !$past(cts_n_pin, 2) && $past(rst_n, 2))
                |-> tx_permit);
            // R2: a high pin two edges back closes the gate at a boundary.
            p_cts_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_at_boundary && cts_gate_en && $past(cts_n_pin, 2)) |-> !tx_permit);
        end
    endgenerate

    // R3: the permit is frozen inside a character.
    p_permit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !tx_at_boundary) |-> $stable(tx_permit));

    // R4: with gating off the pin cannot block a boundary.
    p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_at_boundary && !cts_gate_en) |-> tx_permit);

    // R5: full plus start, without a read, raises RTS.
    p_rts_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_ctl_en && rx_fifo_full && rx_start_det && !rx_fifo_rd)
        |=> (!rts_ctl_en || rts_n_pin));

    // R6: a read lowers RTS in the next cycle.
    p_rts_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_ctl_en && rx_fifo_rd) |=> (!rts_ctl_en || !rts_n_pin));

    // R7: RTS rises under flow control only after full plus start.
    p_rts_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rts_ctl_en && $past(rts_ctl_en) && $rose(rts_n_pin))
        |-> $past(rx_fifo_full && rx_start_det));
endmodule

bind uart_flow_ctrl uart_fc_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/sim_uart_flow_ctrl.sv
module sim_uart_flow_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_gate_en = 1'b0, cts_n_pin = 1'b1, tx_at_boundary = 1'b0;
    logic rts_ctl_en = 1'b0, rx_fifo_full = 1'b0, rx_start_det = 1'b0;
    logic rx_fifo_rd = 1'b0, gpo_level = 1'b0;
    logic tx_permit, rts_n_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state from the requirements.
    logic m_s1, m_s2, m_pq, m_hold;

    always #2 clk = ~clk; // 250 MHz

    uart_flow_ctrl u0 (.*);

    // Reference model: two-stage sync (R1/R2), boundary hold (R3), RTS hold (R5-R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_pq <= 1'b0; m_hold <= 1'b0;
        end else begin
            m_s1 <= cts_n_pin;
            m_s2 <= m_s1;
            if (tx_at_boundary) m_pq <= exp_permit();
            if (!rts_ctl_en || rx_fifo_rd) m_hold <= 1'b0;
            else if (rx_fifo_full && rx_start_det) m_hold <= 1'b1;
        end
    end

    function automatic logic exp_permit();
        if (!tx_at_boundary) return m_pq;
        return !cts_gate_en || !m_s2;
    endfunction

    function automatic logic exp_rts();
        return rts_ctl_en ? m_hold : gpo_level;
    endfunction

    function automatic string permit_tag();
        if (!tx_at_boundary) return "R3";
        if (!cts_gate_en) return "R4";
        return m_s2 ? "R2" : "R1";
    endfunction

    function automatic string rts_tag();
        if (!rts_ctl_en) return "R8";
        return m_hold ? "R5" : "R6/R7";
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic ge, cp, bd, re, ff, sd, rd, gp);
        @(negedge clk);
        cts_gate_en = ge; cts_n_pin = cp; tx_at_boundary = bd;
        rts_ctl_en = re; rx_fifo_full = ff; rx_start_det = sd;
        rx_fifo_rd = rd; gpo_level = gp;
        #1;
        if (rst_n) begin
            check(permit_tag(), tx_permit, exp_permit());
            check(rts_tag(), rts_n_pin, exp_rts());
        end
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ge, cp, re;
        void'($urandom(32'd20240611));
        // R9: reset state.
        @(negedge clk);
        cts_gate_en = 1'b1; cts_n_pin = 1'b0; tx_at_boundary = 1'b1;
        rts_ctl_en = 1'b1; gpo_level = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R9 rts in reset", rts_n_pin, 1'b0);
        check("R9 permit in reset", tx_permit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: pin low reaches the permit after the synchronizer.
        repeat (3) step(1, 0, 1, 1, 0, 0, 0, 0);
        check("R1 directed", tx_permit, 1'b1);
        // R3: CTS goes high mid-character; the permit holds until a boundary.
        step(1, 0, 0, 1, 0, 0, 0, 0);
        repeat (4) step(1, 1, 0, 1, 0, 0, 0, 0);
        check("R3 directed mid-char", tx_permit, 1'b1);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        check("R2 directed boundary", tx_permit, 1'b0);
        // R4: gating off ignores a high pin.
        step(0, 1, 1, 1, 0, 0, 0, 0);
        check("R4 directed", tx_permit, 1'b1);

        // R7: eight start bits on a non-full FIFO leave RTS low.
        repeat (8) step(1, 0, 1, 1, 0, 1, 0, 0);
        check("R7 directed", rts_n_pin, 1'b0);
        // R5: the ninth start bit on a full FIFO raises RTS.
        step(1, 0, 1, 1, 1, 1, 0, 0);
        step(1, 0, 1, 1, 1, 0, 0, 0);
        check("R5 directed", rts_n_pin, 1'b1);
        // R6: held until a read, then low.
        step(1, 0, 1, 1, 1, 1, 0, 0);
        step(1, 0, 1, 1, 1, 0, 1, 0);
        step(1, 0, 1, 1, 0, 0, 0, 0);
        check("R6 directed release", rts_n_pin, 1'b0);
        // R6: a read together with full plus start blocks the rise.
        step(1, 0, 1, 1, 1, 1, 1, 0);
        step(1, 0, 1, 1, 1, 0, 0, 0);
        check("R6 directed same-cycle read", rts_n_pin, 1'b0);
        // R8: disable passes the GPO level; re-enable shows a cleared hold.
        step(1, 0, 1, 1, 1, 1, 0, 0);
        step(1, 0, 1, 0, 1, 0, 0, 1);
        check("R8 gpo high", rts_n_pin, 1'b1);
        step(1, 0, 1, 0, 1, 0, 0, 0);
        check("R8 gpo low", rts_n_pin, 1'b0);
        step(1, 0, 1, 1, 1, 0, 0, 1);
        check("R8 re-enable cleared", rts_n_pin, 1'b0);

        // Constrained random mix.
        ge = 1'b1; cp = 1'b0; re = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(99) < 2)  ge = ~ge;
            if ($urandom_range(99) < 2)  re = ~re;
            if ($urandom_range(99) < 12) cp = ~cp;
            step(ge, cp, $urandom_range(99) < 30, re,
                 $urandom_range(99) < 50, $urandom_range(99) < 20,
                 $urandom_range(99) < 15, $urandom_range(1) == 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule